// File: doc/BRIEF.md
# Control-Word Execution Sequencer

This block sits between an instruction decoder and a register file with an ALU. The decoder hands it an 11-bit packed control word together with a 4-bit source register field and a 4-bit destination register field. The type, direction, operation and width fields of that word choose the path through a short state machine. The machine first picks and reads the operand source, either a general register or the immediate carried with the instruction. It then raises the register-file write enable for one cycle and signals completion.

Register-to-register and immediate-to-register transfers are executed, both as plain moves and as arithmetic/logic operations. Every other combination is rejected in a single busy cycle: memory directions, jump and call types, unknown operations and non-general registers. The rejection raises an unsupported flag and writes nothing. Jump and call words are also flagged as control-flow, so that a separate unit can take them over. A new word is taken only while the sequencer is idle.

Top module: `exec_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `ready` is 1 and every strobe (`rd_en`, `imm_sel`, `wr_en`, `alu_en`, `done`, `unsupported`, `flow_ctl`) is 0.
- R2: A word is accepted on a rising edge where `cw_valid` and `ready` are both 1, and `ready` falls in the next cycle. Any `cw_valid`, `cw`, `src_fld` or `dst_fld` activity while `ready` is 0 has no effect on the outputs.
- R3: A word is supported when all of the following hold. The type `cw[10:8]` is 000 (move) or 001 (arithmetic/logic). The direction `cw[7:5]` is 000 (register to register) or 010 (immediate to register). `dst_fld[3]` is 0. For the register direction, `src_fld[3]` is 0. For arithmetic/logic words, the operation `cw[4:1]` is 0000 to 1011. A supported word is busy for exactly three cycles, called read, write and finish.
- R4: In the read cycle, a register-direction word gives `rd_en`=1, `rd_sel`=`src_fld[2:0]` and `imm_sel`=0. An immediate-direction word gives `imm_sel`=1, `rd_en`=0 and `rd_sel`=0.
- R5: In the write cycle, `wr_en` is 1 and `wr_sel`=`dst_fld[2:0]`. `wr_en` is 1 in no other cycle, and `wr_sel` is 0 whenever `wr_en` is 0.
- R6: For arithmetic/logic words, `alu_op` equals `cw[4:1]` in the read and write cycles, and `alu_en` is 1 in the write cycle. For moves, `alu_en` and `alu_op` stay 0.
- R7: `wide` equals `cw[0]` (1 word, 0 byte) in the read and write cycles and is 0 otherwise.
- R8: `done` is 1 for exactly one cycle, the last busy cycle, and `ready` is 1 in the cycle after it.
- R9: An unsupported word is busy for one cycle, in which `done` and `unsupported` are 1 and `rd_en`, `imm_sel` and `wr_en` are 0.
- R10: In that rejection cycle, `flow_ctl` is 1 when the type is 010 (jump) or 100 (call/return) and is 0 for all other types.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cw_valid | input | 1 | Control word present |
| cw | input | 11 | Packed control word: type, direction, operation, width |
| src_fld | input | 4 | Source register field |
| dst_fld | input | 4 | Destination register field |
| ready | output | 1 | Idle, able to take a word |
| rd_en | output | 1 | General-register read strobe |
| rd_sel | output | 3 | Register to read |
| imm_sel | output | 1 | Operand taken from the immediate |
| wr_en | output | 1 | Register write enable |
| wr_sel | output | 3 | Register to write |
| wide | output | 1 | Word-width operand |
| alu_en | output | 1 | Write data comes from the ALU |
| alu_op | output | 4 | ALU operation code |
| done | output | 1 | Sequence completion pulse |
| unsupported | output | 1 | Word rejected without effect |
| flow_ctl | output | 1 | Rejected word was a jump or call |

## Verification
Each busy cycle shows only one state's strobes at the ports. A wrong path or a lost state is therefore visible in the first cycle after acceptance: `rd_en` or `imm_sel` would be missing, `done` would come too early, or an unsupported word would produce a write. A fault in the latched fields, such as a corrupted select, operation or width bit, shows in the read or write cycle of the same word. A word that the machine wrongly takes while busy changes the outputs within one cycle.

// File: rtl/exec_seq_pkg.sv
package exec_seq_pkg;

    localparam int CW_W   = 11;
    localparam int FLD_W  = 4;
    localparam int SEL_W  = FLD_W - 1;
    localparam int OP_W   = 4;
    localparam int TY_W   = 3;
    localparam int DIR_W  = 3;

    localparam int TY_HI  = CW_W - 1;
    localparam int TY_LO  = CW_W - TY_W;
    localparam int DIR_HI = TY_LO - 1;
    localparam int DIR_LO = TY_LO - DIR_W;
    localparam int OP_HI  = DIR_LO - 1;
    localparam int OP_LO  = 1;

    localparam logic [TY_W-1:0]  TY_MOVE = 3'b000;
    localparam logic [TY_W-1:0]  TY_ARLG = 3'b001;
    localparam logic [TY_W-1:0]  TY_JUMP = 3'b010;
    localparam logic [TY_W-1:0]  TY_CALL = 3'b100;

    localparam logic [DIR_W-1:0] DIR_REG = 3'b000;
    localparam logic [DIR_W-1:0] DIR_IMM = 3'b010;

    localparam logic [OP_W-1:0]  OP_LAST = 4'b1011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_FINISH,
        ST_REJECT
    } seq_state_t;

    typedef struct packed {
        logic             ok;
        logic             is_alu;
        logic             from_imm;
        logic             flow;
        logic             wide;
        logic [OP_W-1:0]  op;
        logic [SEL_W-1:0] src;
        logic [SEL_W-1:0] dst;
    } plan_t;

    function automatic logic op_known(input logic [OP_W-1:0] op);
        return op <= OP_LAST;
    endfunction

    function automatic logic is_flow_type(input logic [TY_W-1:0] ty);
        return (ty == TY_JUMP) || (ty == TY_CALL);
    endfunction

endpackage

// File: rtl/exec_seq_decode.sv
module exec_seq_decode
    import exec_seq_pkg::*;
(
    input  logic [CW_W-1:0]  cw,
    input  logic [FLD_W-1:0] src_fld,
    input  logic [FLD_W-1:0] dst_fld,
    output plan_t            plan
);
    logic [TY_W-1:0]  ty;
    logic [DIR_W-1:0] dir;
    logic [OP_W-1:0]  op;
    logic             type_ok;
    logic             dir_ok;
    logic             src_ok;
    logic             dst_ok;
    logic             op_ok;

    always_comb begin
        ty      = cw[TY_HI:TY_LO];
        dir     = cw[DIR_HI:DIR_LO];
        op      = cw[OP_HI:OP_LO];
        type_ok = (ty == TY_MOVE) || (ty == TY_ARLG);
        dir_ok  = (dir == DIR_REG) || (dir == DIR_IMM);
        src_ok  = (dir == DIR_IMM) || !src_fld[FLD_W-1];
        dst_ok  = !dst_fld[FLD_W-1];
        op_ok   = (ty != TY_ARLG) || op_known(op);

        plan          = '0;
        plan.ok       = type_ok && dir_ok && src_ok && dst_ok && op_ok;
        plan.is_alu   = (ty == TY_ARLG);
        plan.from_imm = (dir == DIR_IMM);
        plan.flow     = is_flow_type(ty);
        plan.wide     = cw[0];
        plan.op       = (ty == TY_ARLG) ? op : '0;
        plan.src      = src_fld[SEL_W-1:0];
        plan.dst      = dst_fld[SEL_W-1:0];
    end
endmodule

// File: rtl/exec_seq_fsm.sv
module exec_seq_fsm
    import exec_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  plan_t      plan_in,
    output seq_state_t state,
    output plan_t      plan_q
);
    seq_state_t state_nx;

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: begin
                if (accept) state_nx = plan_in.ok ? ST_READ : ST_REJECT;
            end
            ST_READ:   state_nx = ST_WRITE;
            ST_WRITE:  state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            ST_REJECT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            plan_q <= '0;
        end else begin
            state <= state_nx;
            if (accept && state == ST_IDLE) plan_q <= plan_in;
        end
    end
endmodule

// File: rtl/exec_seq_drive.sv
module exec_seq_drive
    import exec_seq_pkg::*;
(
    input  seq_state_t       state,
    input  plan_t            plan_q,
    output logic             rd_en,
    output logic [SEL_W-1:0] rd_sel,
    output logic             imm_sel,
    output logic             wr_en,
    output logic [SEL_W-1:0] wr_sel,
    output logic             wide,
    output logic             alu_en,
    output logic [OP_W-1:0]  alu_op,
    output logic             done,
    output logic             unsupported,
    output logic             flow_ctl
);
    always_comb begin
        rd_en       = 1'b0;
        rd_sel      = '0;
        imm_sel     = 1'b0;
        wr_en       = 1'b0;
        wr_sel      = '0;
        wide        = 1'b0;
        alu_en      = 1'b0;
        alu_op      = '0;
        done        = 1'b0;
        unsupported = 1'b0;
        flow_ctl    = 1'b0;
        case (state)
            ST_READ: begin
                imm_sel = plan_q.from_imm;
                rd_en   = !plan_q.from_imm;
                rd_sel  = plan_q.from_imm ? '0 : plan_q.src;
                wide    = plan_q.wide;
                alu_op  = plan_q.op;
            end
            ST_WRITE: begin
                wr_en  = 1'b1;
                wr_sel = plan_q.dst;
                wide   = plan_q.wide;
                alu_en = plan_q.is_alu;
                alu_op = plan_q.op;
            end
            ST_FINISH: begin
                done = 1'b1;
            end
            ST_REJECT: begin
                done        = 1'b1;
                unsupported = 1'b1;
                flow_ctl    = plan_q.flow;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/exec_seq.sv
module exec_seq
    import exec_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cw_valid,
    input  logic [CW_W-1:0]  cw,
    input  logic [FLD_W-1:0] src_fld,
    input  logic [FLD_W-1:0] dst_fld,
    output logic             ready,
    output logic             rd_en,
    output logic [SEL_W-1:0] rd_sel,
    output logic             imm_sel,
    output logic             wr_en,
    output logic [SEL_W-1:0] wr_sel,
    output logic             wide,
    output logic             alu_en,
    output logic [OP_W-1:0]  alu_op,
    output logic             done,
    output logic             unsupported,
    output logic             flow_ctl
);
    plan_t      plan_in;
    plan_t      plan_q;
    seq_state_t state;
    logic       accept;

    assign ready  = (state == ST_IDLE);
    assign accept = cw_valid && ready;

    exec_seq_decode u_decode (
        .cw      (cw),
        .src_fld (src_fld),
        .dst_fld (dst_fld),
        .plan    (plan_in)
    );

    exec_seq_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .plan_in (plan_in),
        .state   (state),
        .plan_q  (plan_q)
    );

    exec_seq_drive u_drive (
        .state       (state),
        .plan_q      (plan_q),
        .rd_en       (rd_en),
        .rd_sel      (rd_sel),
        .imm_sel     (imm_sel),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wide        (wide),
        .alu_en      (alu_en),
        .alu_op      (alu_op),
        .done        (done),
        .unsupported (unsupported),
        .flow_ctl    (flow_ctl)
    );
endmodule

// File: rtl/exec_seq_chk.sv
module exec_seq_chk (
    input logic clk,
    input logic rst,
    input logic cw_valid,
    input logic ready,
    input logic rd_en,
    input logic imm_sel,
    input logic wr_en,
    input logic wide,
    input logic alu_en,
    input logic done,
    input logic unsupported,
    input logic flow_ctl
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (ready && !done && !wr_en && !rd_en && !imm_sel));

    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (ready && cw_valid) |=> !ready);

    assert_read_then_write_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_en || imm_sel) |=> wr_en);

    assert_single_source_R4: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && imm_sel));

    assert_write_single_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    assert_alu_with_write_R6: assert property (@(posedge clk) disable iff (rst)
        alu_en |-> wr_en);

    assert_width_steady_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $stable(wide));

    assert_done_then_ready_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> (ready && !done));

    assert_write_then_done_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> done);

    assert_reject_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        unsupported |-> (done && !wr_en && !rd_en && !imm_sel));

    assert_flow_rejected_R10: assert property (@(posedge clk) disable iff (rst)
        flow_ctl |-> unsupported);
endmodule

bind exec_seq exec_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cw_valid    (cw_valid),
    .ready       (ready),
    .rd_en       (rd_en),
    .imm_sel     (imm_sel),
    .wr_en       (wr_en),
    .wide        (wide),
    .alu_en      (alu_en),
    .done        (done),
    .unsupported (unsupported),
    .flow_ctl    (flow_ctl)
);

// File: tb/test_exec_seq.sv
`timescale 1ns/1ps
module test_exec_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cw_valid = 1'b0;
    logic [10:0] cw = '0;
    logic [3:0]  src_fld = '0;
    logic [3:0]  dst_fld = '0;
    logic        ready, rd_en, imm_sel, wr_en, wide, alu_en, done, unsupported, flow_ctl;
    logic [2:0]  rd_sel, wr_sel;
    logic [3:0]  alu_op;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    exec_seq i_exec_seq (
        .clk(clk), .rst(rst), .cw_valid(cw_valid), .cw(cw),
        .src_fld(src_fld), .dst_fld(dst_fld), .ready(ready),
        .rd_en(rd_en), .rd_sel(rd_sel), .imm_sel(imm_sel),
        .wr_en(wr_en), .wr_sel(wr_sel), .wide(wide), .alu_en(alu_en),
        .alu_op(alu_op), .done(done), .unsupported(unsupported),
        .flow_ctl(flow_ctl)
    );

    function automatic logic [18:0] pack(input logic rdy, input logic re, input logic [2:0] rs,
                                         input logic im, input logic we, input logic [2:0] ws,
                                         input logic wd, input logic ae, input logic [3:0] ao,
                                         input logic dn, input logic un, input logic fl);
        return {rdy, re, rs, im, we, ws, wd, ae, ao, dn, un, fl};
    endfunction

    function automatic logic [18:0] observed();
        return pack(ready, rd_en, rd_sel, imm_sel, wr_en, wr_sel, wide, alu_en,
                    alu_op, done, unsupported, flow_ctl);
    endfunction

    task automatic check(input string tag, input logic [18:0] exp);
        logic [18:0] act;
        act = observed();
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cw=%h src=%h dst=%h actual=%b expected=%b",
                     tag, cw, src_fld, dst_fld, act, exp);
        end
    endtask

    // Caller is at a falling edge with the sequencer idle; returns at a falling edge, idle again.
    task automatic run_one(input logic [10:0] w, input logic [3:0] s, input logic [3:0] d,
                           input logic noise);
        logic [2:0] ty, dir;
        logic [3:0] op;
        logic       is_alu, is_reg, ok, flow, wb;
        logic [3:0] aop;
        ty = w[10:8]; dir = w[7:5]; op = w[4:1]; wb = w[0];
        is_alu = (ty == 3'b001);
        is_reg = (dir == 3'b000);
        ok = ((ty == 3'b000) || is_alu) && (is_reg || dir == 3'b010) && !d[3]
             && (!is_reg || !s[3]) && (!is_alu || op <= 4'd11);
        flow = (ty == 3'b010) || (ty == 3'b100);
        aop = is_alu ? op : 4'd0;

        cw = w; src_fld = s; dst_fld = d; cw_valid = 1'b1;
        check("R2 idle before accept", pack(1,0,0,0,0,0,0,0,0,0,0,0));
        @(negedge clk);
        if (noise) begin
            cw = ~w; src_fld = ~s; dst_fld = ~d; cw_valid = 1'b1;
        end else begin
            cw_valid = 1'b0;
        end
        if (ok) begin
            // R3 R4 R6 R7 read cycle
            check("R3 R4 R6 R7 read", pack(0, is_reg, is_reg ? s[2:0] : 3'd0, !is_reg,
                                          0, 0, wb, 0, aop, 0, 0, 0));
            @(negedge clk);
            check("R5 R6 R7 write", pack(0, 0, 0, 0, 1, d[2:0], wb, is_alu, aop, 0, 0, 0));
            @(negedge clk);
            check("R8 finish", pack(0,0,0,0,0,0,0,0,0,1,0,0));
        end else begin
            check("R9 R10 reject", pack(0,0,0,0,0,0,0,0,0,1,1,flow));
        end
        cw_valid = 1'b0;
        @(negedge clk);
        check("R2 R8 ready after done", pack(1,0,0,0,0,0,0,0,0,0,0,0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 during reset", pack(1,0,0,0,0,0,0,0,0,0,0,0));
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", pack(1,0,0,0,0,0,0,0,0,0,0,0));
        for (int i = 0; i < 2048; i++) begin
            run_one(11'(i), 4'((i * 5 + 3) % 16), 4'((i * 7 + 1) % 16), 1'b0);
        end
        for (int i = 0; i < 2048; i++) begin
            run_one(11'(i), 4'((i * 3) % 8), 4'((i * 11 + 2) % 8), 1'b1);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule